// File: doc/BRIEF.md
# Free-Running Timer with Input Capture and Compare Clear

A 16-bit up-counter advances on cycles where one of four externally supplied rate strobes is high. A two-bit field in the control register chooses the strobe. A compare register sets a compare flag when the count reaches it. A status bit can turn that match into a counter reset, which makes the count period programmable. Counter wrap from all-ones to zero sets a sticky overflow flag. Software can clear that flag only by reading it as 1 and then writing 0 to it.

Four capture inputs, channels A to D, each pass through a two-flop synchronizer. On the edge chosen by that channel's polarity bit, the channel copies the counter into its capture register and sets its capture flag. All state is reached through a simple register bus with single-cycle writes and combinational reads. A low-power mode input holds the control register at zero.

Top module: `frt_capcmp`

## Requirements
- R1: The counter grows by exactly one on each cycle where the strobe `tick_en[sel]` is high, with `sel` being control bits [1:0]. On all other cycles it holds its value.
- R2: A count step taken while the counter is 16'hFFFF moves it to 16'h0000 and sets the overflow flag, which is status bit 1.
- R3: A status write with bit 1 at 0 clears the overflow flag only if a status read has returned the flag as 1 since the last such clear. A write of 0 with no such read leaves the flag set. Writing 1 has no effect.
- R4: Status bit 0 is the clear-on-match control. A count step taken while the counter equals compare register A sets the compare flag, status bit 2. When bit 0 is 1, that step loads 0 into the counter instead of adding one. When bit 0 is 0, counting continues past the match.
- R5: A bus write to the counter in the same cycle as a count step wins. The counter takes the written value, and that step sets no flag.
- R6: The control register is 8'h00 after reset. It is forced to 8'h00, with writes ignored, on every cycle where `lp_mode` is high. All eight of its bits read back as written.
- R7: Control bits 7, 6, 5 and 4 select the capture polarity of channels A, B, C and D. A value of 0 captures on a falling input edge and 1 captures on a rising edge. The opposite edge causes no capture.
- R8: A capture copies the current counter value into that channel's capture register and sets that channel's capture flag. The flags for A to D sit at status bits 3 to 6. Writing 0 to a capture flag or to the compare flag clears it, and writing 1 leaves it unchanged.
- R9: The register addresses are: 0 counter, 1 compare A, 2 control, 3 status, and 4 to 7 the capture registers A to D (read-only).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lp_mode | input | 1 | Low-power mode, holds control register at zero |
| tick_en | input | 4 | Prescaled count strobes, one per clock-select value |
| cap_in | input | 4 | Capture inputs, bit 0 is channel A |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms the overflow clear) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| ovf_flag | output | 1 | Overflow flag |
| cmp_flag | output | 1 | Compare A match flag |
| cap_flag | output | 4 | Capture flags, bit 0 is channel A |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high in the same cycle. They also assume the capture inputs are stable levels that change at most once every few cycles, so each synchronized edge is seen once. The bench drives bus cycles one at a time from tasks. It changes the capture inputs only when the counter is held still, and waits four cycles after each change. The strobes are random on every cycle, and writes to the counter, compare register and status register are random within bounds that make matches and wraps occur.

// File: rtl/frt_pkg.sv
package frt_pkg;
  typedef enum logic [2:0] {
    A_COUNT = 3'd0,
    A_CMPA  = 3'd1,
    A_CTRL  = 3'd2,
    A_STAT  = 3'd3,
    A_CAPA  = 3'd4,
    A_CAPB  = 3'd5,
    A_CAPC  = 3'd6,
    A_CAPD  = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic [3:0] edge_rise;  // [3]=A ... [0]=D
    logic [1:0] buf_en;
    logic [1:0] clk_sel;
  } ctrl_t;

  localparam int unsigned N_CH = 4;
  localparam int unsigned STAT_CCL = 0;
  localparam int unsigned STAT_OVF = 1;
  localparam int unsigned STAT_CMP = 2;
  localparam int unsigned STAT_CAP = 3;
endpackage

// File: rtl/frt_counter.sv
module frt_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         wr_cnt,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] cmp,
  input  logic         ccl,
  output logic [W-1:0] cnt,
  output logic         count_ev,
  output logic         match_ev,
  output logic         wrap_ev
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  function automatic logic [W-1:0] next_count(input logic [W-1:0] c,
                                              input logic [W-1:0] m,
                                              input logic clr);
    if (clr && c == m) return '0;
    return c + {{(W-1){1'b0}}, 1'b1};
  endfunction

  assign count_ev = step & ~wr_cnt;
  assign match_ev = count_ev & (cnt == cmp);
  assign wrap_ev  = count_ev & (cnt == ALL_ONES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (wr_cnt)  cnt <= wdata;
    else if (step)    cnt <= next_count(cnt, cmp, ccl);
  end
endmodule

// File: rtl/frt_cap_chan.sv
module frt_cap_chan #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         din,
  input  logic         rise_sel,
  input  logic [W-1:0] cnt,
  output logic         cap_ev,
  output logic [W-1:0] cap_val
);
  logic s1, s2, s3;

  function automatic logic edge_hit(input logic now, input logic prev, input logic rise);
    return rise ? (now & ~prev) : (~now & prev);
  endfunction

  assign cap_ev = edge_hit(s2, s3, rise_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
      cap_val <= '0;
    end else begin
      s1 <= din;
      s2 <= s1;
      s3 <= s2;
      if (cap_ev) cap_val <= cnt;
    end
  end
endmodule

// File: rtl/frt_capcmp.sv
module frt_capcmp
  import frt_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lp_mode,
  input  logic [3:0]   tick_en,
  input  logic [3:0]   cap_in,
  input  logic [2:0]   bus_addr,
  input  logic         bus_wr,
  input  logic         bus_rd,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  output logic         ovf_flag,
  output logic         cmp_flag,
  output logic [3:0]   cap_flag
);
  ctrl_t        ctrl;
  logic [W-1:0] cmpa;
  logic         ccl;
  logic         ovf_armed;
  logic [W-1:0] cnt;
  logic         step, count_ev, match_ev, wrap_ev;
  logic         wr_cnt, wr_cmp, wr_ctl, stat_wr;
  logic [3:0]   cap_ev;
  logic [W-1:0] cap_val [N_CH];
  logic [7:0]   stat_word;

  assign wr_cnt  = bus_wr && bus_addr == A_COUNT;
  assign wr_cmp  = bus_wr && bus_addr == A_CMPA;
  assign wr_ctl  = bus_wr && bus_addr == A_CTRL;
  assign stat_wr = bus_wr && bus_addr == A_STAT;
  assign step    = tick_en[ctrl.clk_sel];

  frt_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .wr_cnt(wr_cnt), .wdata(bus_wdata),
    .cmp(cmpa), .ccl(ccl), .cnt(cnt), .count_ev(count_ev),
    .match_ev(match_ev), .wrap_ev(wrap_ev)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_cap
    frt_cap_chan #(.W(W)) u_chan (
      .clk(clk), .rst_n(rst_n), .din(cap_in[i]),
      .rise_sel(ctrl.edge_rise[N_CH-1-i]), .cnt(cnt),
      .cap_ev(cap_ev[i]), .cap_val(cap_val[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      cmpa <= '1;
    end else begin
      if (lp_mode)     ctrl <= '0;
      else if (wr_ctl) ctrl <= bus_wdata[7:0];
      if (wr_cmp)      cmpa <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccl       <= 1'b0;
      ovf_flag  <= 1'b0;
      ovf_armed <= 1'b0;
      cmp_flag  <= 1'b0;
      cap_flag  <= '0;
    end else begin
      if (stat_wr) ccl <= bus_wdata[STAT_CCL];
      if (bus_rd && bus_addr == A_STAT && ovf_flag) ovf_armed <= 1'b1;
      if (wrap_ev) begin
        ovf_flag <= 1'b1;
      end else if (stat_wr && !bus_wdata[STAT_OVF] && ovf_armed) begin
        ovf_flag  <= 1'b0;
        ovf_armed <= 1'b0;
      end
      if (match_ev)                         cmp_flag <= 1'b1;
      else if (stat_wr && !bus_wdata[STAT_CMP]) cmp_flag <= 1'b0;
      for (int i = 0; i < N_CH; i++) begin
        if (cap_ev[i])                               cap_flag[i] <= 1'b1;
        else if (stat_wr && !bus_wdata[STAT_CAP+i])  cap_flag[i] <= 1'b0;
      end
    end
  end

  assign stat_word = {1'b0, cap_flag, cmp_flag, ovf_flag, ccl};

  always_comb begin
    unique case (bus_addr)
      A_COUNT: bus_rdata = cnt;
      A_CMPA:  bus_rdata = cmpa;
      A_CTRL:  bus_rdata = {{(W-8){1'b0}}, ctrl};
      A_STAT:  bus_rdata = {{(W-8){1'b0}}, stat_word};
      A_CAPA:  bus_rdata = cap_val[0];
      A_CAPB:  bus_rdata = cap_val[1];
      A_CAPC:  bus_rdata = cap_val[2];
      default: bus_rdata = cap_val[3];
    endcase
  end
endmodule

// File: rtl/frt_capcmp_chk.sv
module frt_capcmp_chk
  import frt_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         lp_mode,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] cnt,
  input logic         count_ev,
  input logic         match_ev,
  input logic         wrap_ev,
  input logic         wr_cnt,
  input logic         stat_wr,
  input logic         ccl,
  input logic         ovf_flag,
  input ctrl_t        ctrl,
  input logic [3:0]   cap_ev,
  input logic [3:0]   cap_flag
);
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    count_ev && !(match_ev && ccl) |=> cnt == W'($past(cnt) + 1'b1)); // R1
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !count_ev && !wr_cnt |=> $stable(cnt)); // R1
  AST_WRAP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ev |=> ovf_flag); // R2
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !stat_wr |=> ovf_flag); // R3
  AST_MATCH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    match_ev && ccl |=> cnt == '0); // R4
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt == $past(bus_wdata)); // R5
  AST_LOWPOWER_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    lp_mode |=> ctrl == '0); // R6
  AST_CAPTURE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    |cap_ev |=> (cap_flag & $past(cap_ev)) == $past(cap_ev)); // R8
endmodule

bind frt_capcmp frt_capcmp_chk #(.W(W)) i_chk (.*);

// File: tb/test_frt_capcmp.sv
module test_frt_capcmp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lp_mode = 1'b0;
  logic [3:0]  tick_en = '0;
  logic [3:0]  cap_in = '0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        ovf_flag, cmp_flag;
  logic [3:0]  cap_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  frt_capcmp i_frt_capcmp (.*);

  always #5 clk = ~clk;

  function automatic logic [15:0] model_next(input logic [15:0] c, input logic [15:0] m,
                                             input logic clr);
    if (clr && c == m) return 16'h0000;
    return c + 16'h0001;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic tick(input logic [3:0] m);
    tick_en = m;
    @(negedge clk);
    tick_en = '0;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #1500us;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] d, ecnt, ecmp;
    logic [1:0]  sel;
    logic        eccl, eovf, ecmpf;
    void'($urandom(32'd2024));
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);

    rd(3'd2, d); check("R6 reset ctrl", d, 16'h0000);
    rd(3'd0, d); check("R9 reset counter", d, 16'h0000);
    rd(3'd3, d); check("R2 reset status", d, 16'h0000);

    // R6 readback and low-power clear
    wr(3'd2, 16'h00A5);
    rd(3'd2, d); check("R6 ctrl readback", d, 16'h00A5);
    lp_mode = 1'b1; wr(3'd2, 16'h005A); lp_mode = 1'b0;
    rd(3'd2, d); check("R6 ctrl low-power", d, 16'h0000);

    // R1/R4 random: strobes, compare and clear-on-match
    eovf = 1'b0; ecmpf = 1'b0;
    for (int b = 0; b < 40; b++) begin
      sel  = 2'($urandom_range(0, 3));
      ecmp = 16'($urandom_range(0, 40));
      eccl = 1'($urandom_range(0, 1));
      ecnt = ($urandom_range(0, 1) == 1) ? 16'($urandom_range(16'hFFE0, 16'hFFFF))
                                         : 16'($urandom_range(0, 30));
      wr(3'd2, {14'd0, sel});
      wr(3'd1, ecmp);
      wr(3'd3, {9'd0, 5'b11111, 1'b1, eccl});
      wr(3'd0, ecnt);
      for (int c = 0; c < 60; c++) begin
        logic [3:0] m;
        m = 4'($urandom);
        if (m[sel]) begin
          if (ecnt == 16'hFFFF) eovf = 1'b1;
          if (ecnt == ecmp) ecmpf = 1'b1;
          ecnt = model_next(ecnt, ecmp, eccl);
        end
        tick(m);
      end
      rd(3'd0, d); check("R1 random counter", d, ecnt);
      rd(3'd3, d); check("R4 random flags", d[2:0], {13'd0, ecmpf, eovf, eccl});
    end

    // clear flags: read status so overflow clear is armed
    rd(3'd3, d);
    wr(3'd3, 16'h0000);
    rd(3'd3, d); check("R8 flags cleared by write 0", d, 16'h0000);

    // R4 directed
    wr(3'd2, 16'h0000); wr(3'd1, 16'd5); wr(3'd3, 16'h0001); wr(3'd0, 16'd0);
    for (int i = 0; i < 6; i++) tick(4'b0001);
    rd(3'd0, d); check("R4 clear on match", d, 16'd0);
    check("R4 compare flag", {15'd0, cmp_flag}, 16'd1);
    wr(3'd3, 16'h0000); wr(3'd0, 16'd0);
    for (int i = 0; i < 6; i++) tick(4'b0001);
    rd(3'd0, d); check("R4 run through match", d, 16'd6);

    // R1 unselected strobes
    wr(3'd2, 16'h0002);
    tick(4'b1011);
    rd(3'd0, d); check("R1 unselected strobe", d, 16'd6);

    // R5 write wins over count
    tick_en = 4'b1111; wr(3'd0, 16'h1234); tick_en = '0;
    rd(3'd0, d); check("R5 write priority", d, 16'h1234);

    // R2/R3 overflow
    wr(3'd2, 16'h0000); wr(3'd1, 16'h0010); wr(3'd0, 16'hFFFE);
    tick(4'b0001); tick(4'b0001);
    rd(3'd0, d); check("R2 wrap to zero", d, 16'h0000);
    check("R2 overflow set", {15'd0, ovf_flag}, 16'd1);
    wr(3'd3, 16'h007C);
    check("R3 write 0 without read", {15'd0, ovf_flag}, 16'd1);
    rd(3'd3, d); check("R3 read shows flag", d[1], 1'b1);
    wr(3'd3, 16'h007C);
    check("R3 cleared after read", {15'd0, ovf_flag}, 16'd0);

    // R7/R8 capture
    wr(3'd2, 16'h0080);        // A rising, B falling
    wr(3'd0, 16'h0ABC);
    cap_in[0] = 1'b1; wait_n(4);
    rd(3'd4, d); check("R8 capture A value", d, 16'h0ABC);
    check("R8 capture A flag", {12'd0, cap_flag}, 16'h0001);
    wr(3'd0, 16'h0BCD);
    cap_in[1] = 1'b1; wait_n(4);
    check("R7 rising ignored on falling channel", {12'd0, cap_flag}, 16'h0001);
    rd(3'd5, d); check("R7 capture B untouched", d, 16'h0000);
    cap_in[1] = 1'b0; wait_n(4);
    rd(3'd5, d); check("R7 falling captured", d, 16'h0BCD);
    cap_in[0] = 1'b0; wait_n(4);
    rd(3'd4, d); check("R7 falling ignored on rising channel", d, 16'h0ABC);
    wr(3'd3, 16'h0006);
    check("R8 capture flags cleared", {12'd0, cap_flag}, 16'h0000);

    finish_run();
  end
endmodule